// File: doc/BRIEF.md
# SPI Memory Read Pointer Sequencer

This block is the read engine of an SPI slave that serves a 9-bit byte address space. The bus runs with the clock idling high. The slave samples input bits on rising SCK edges and changes its output on falling edges. A system clock oversamples SCK, chip select and MOSI through two-stage synchronisers, so SCK must stay well below the system clock rate. A read begins with an instruction byte of the form `0000_h011`, where bit 3 (`h`) is address bit 8. The low eight address bits follow in a second byte. The block then answers with a status byte, followed by a stream of memory bytes, each sent MSB first.

The address pointer follows several special rules. Reads normally step upward and wrap from 0x135 to 0x000. A start address of 0x126 or 0x127 makes the pointer alternate between those two addresses, which allows fast repeated port reads. Addresses 0x136 to 0x1FF are not implemented: they return 0x00, and the pointer keeps counting until it rolls over to 0x000. The eight clock/calendar bytes at 0x128 to 0x12F are served from a snapshot of the live counters, taken when the last address bit arrives.

The memory array is outside the block. It is reached through an address output and a combinational data input. The live clock counters come in on a flat bus, with byte k serving address 0x128+k. The status byte is supplied by the surrounding logic.

Top module: `spi_read_seq`

## Requirements
- R1: `misoOe` is 0 after reset, while `csN` is high, and throughout the instruction and address bytes.
- R2: An instruction byte whose bits 7..4 are not 0000 or whose bits 2..0 are not 011 is ignored: `misoOe` stays 0 until `csN` rises.
- R3: The first byte shifted out after the address byte is the value of `statusIn`. Memory data follows it.
- R4: Each output byte is sent MSB first over 8 falling SCK edges. The falling edge that ends bit 0 of one byte starts bit 7 of the next. `misoOut` changes only in response to a falling SCK edge.
- R5: Outside toggle mode, the pointer advances by one after each data byte and wraps from 0x135 to 0x000.
- R6: When the start address is 0x126 or 0x127, the pointer alternates between 0x126 and 0x127 after every byte.
- R7: A pointer in 0x136..0x1FF yields a 0x00 byte and still increments. After it rolls over to 0x000, real data is returned.
- R8: Addresses 0x128+k (k = 0..7) return byte k (bits 8k+7..8k) of `rtcLive` as it was when the last address bit was sampled. Later changes to `rtcLive` within the same transfer are not seen.
- R9: Raising `csN` aborts a transfer at any point. The next selection starts again with instruction decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rstN | input | 1 | Active-low synchronous reset |
| sckIn | input | 1 | SPI clock, idles high |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| statusIn | input | 8 | Status byte returned first in each read |
| memData | input | 8 | Memory read data for `memAddr` (combinational) |
| rtcLive | input | 64 | Live clock/calendar bytes, byte k at bits 8k+7..8k |
| memAddr | output | 9 | Current read pointer, presented to the memory |
| misoOut | output | 1 | Serial data to the master |
| misoOe | output | 1 | Output enable for MISO (0 = high impedance) |

## Verification
The assertions check four behaviours on every cycle. The output is released shortly after deselect. `misoOut` moves only when the control issues a load or shift strobe. Each byte load steps the pointer by one, with the 0x135 wrap, or flips it between 0x126 and 0x127 in toggle mode. A byte loaded from an unimplemented address drives a 0 onto MISO. Other behaviours need whole transfers and so are shown only by the bench scenarios. These are the decoding of the opcode with its embedded address bit, the status byte coming first, the snapshot ignoring later counter changes, rejected opcodes, and recovery after an aborted transfer.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // last address bit sampled
    logic loadStatus;  // start of first output byte
    logic loadByte;    // start of a memory byte, advance pointer
    logic shiftOut;    // move next bit to MISO
  } dpCtrl_t;

endpackage

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 9,
  parameter logic [2:0] OPC_TAIL = 3'b011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csN,
  input  logic              mosi,
  output dpCtrl_t           ctl,
  output logic [ADDR_W-1:0] capAddr,
  output logic              misoOe
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [1:0] sckSync, csSync, mosiSync;
  logic       sckPrev;
  logic       sckRise, sckFall, csActive;

  phase_e           phase;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftIn, nextIn;
  logic             addrHi;
  logic             firstPend;
  logic             oeReg;
  logic             opcOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckSync  <= 2'b11;
      csSync   <= 2'b11;
      mosiSync <= 2'b00;
      sckPrev  <= 1'b1;
    end else begin
      sckSync  <= {sckSync[0], sckIn};
      csSync   <= {csSync[0], csN};
      mosiSync <= {mosiSync[0], mosi};
      sckPrev  <= sckSync[1];
    end
  end

  assign sckRise  = sckSync[1] & ~sckPrev;
  assign sckFall  = ~sckSync[1] & sckPrev;
  assign csActive = ~csSync[1];

  assign nextIn  = {shiftIn[BYTE_W-2:0], mosiSync[1]};
  assign capAddr = {addrHi, nextIn};
  assign opcOk   = (nextIn[7:4] == 4'b0000) && (nextIn[2:0] == OPC_TAIL);

  always_comb begin
    ctl = '0;
    if (csActive && phase == PH_ADDR && sckRise && bitCnt == LAST_BIT)
      ctl.capture = 1'b1;
    if (csActive && phase == PH_DATA && sckFall) begin
      if (bitCnt == '0) begin
        if (firstPend) ctl.loadStatus = 1'b1;
        else           ctl.loadByte   = 1'b1;
      end else begin
        ctl.shiftOut = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !csActive) begin
      phase     <= PH_CMD;
      bitCnt    <= '0;
      shiftIn   <= '0;
      addrHi    <= 1'b0;
      firstPend <= 1'b1;
      oeReg     <= 1'b0;
    end else begin
      unique case (phase)
        PH_CMD: if (sckRise) begin
          shiftIn <= nextIn;
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) begin
            addrHi <= nextIn[3];
            phase  <= opcOk ? PH_ADDR : PH_SKIP;
          end
        end
        PH_ADDR: if (sckRise) begin
          shiftIn <= nextIn;
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) phase <= PH_DATA;
        end
        PH_DATA: if (sckFall) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == '0) begin
            firstPend <= 1'b0;
            oeReg     <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign misoOe = oeReg;

endmodule

// File: rtl/spi_rd_dp.sv
module spi_rd_dp
  import spi_rd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] LAST_ADDR = 9'h135,
  parameter logic [ADDR_W-1:0] TOG_ADDR  = 9'h126,
  parameter logic [ADDR_W-1:0] CLK_BASE  = 9'h128,
  parameter int CLK_BYTES = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpCtrl_t                     ctl,
  input  logic [ADDR_W-1:0]           capAddr,
  input  logic [BYTE_W-1:0]           statusIn,
  input  logic [BYTE_W-1:0]           memData,
  input  logic [CLK_BYTES*BYTE_W-1:0] rtcLive,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        misoOut,
  output logic                        toggleMode
);

  localparam int CIDX_W = (CLK_BYTES > 1) ? $clog2(CLK_BYTES) : 1;
  localparam logic [ADDR_W-1:0] CLK_END = CLK_BASE + ADDR_W'(CLK_BYTES - 1);

  logic [ADDR_W-1:0] ptr, nextPtr, clkOff;
  logic [BYTE_W-1:0] snap [CLK_BYTES];
  logic [BYTE_W-1:0] txShift, byteSel;
  logic              togMode;

  // one snapshot register per clock byte
  for (genvar g = 0; g < CLK_BYTES; g++) begin : gSnap
    always_ff @(posedge clk) begin
      if (!rstN)            snap[g] <= '0;
      else if (ctl.capture) snap[g] <= rtcLive[g*BYTE_W +: BYTE_W];
    end
  end

  assign clkOff = ptr - CLK_BASE;

  always_comb begin
    if (ptr > LAST_ADDR)
      byteSel = '0;
    else if (ptr >= CLK_BASE && ptr <= CLK_END)
      byteSel = snap[clkOff[CIDX_W-1:0]];
    else
      byteSel = memData;
  end

  always_comb begin
    if (togMode)                nextPtr = ptr ^ ADDR_W'(1);
    else if (ptr == LAST_ADDR)  nextPtr = '0;
    else                        nextPtr = ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      togMode <= 1'b0;
      txShift <= '0;
    end else begin
      if (ctl.capture) begin
        ptr     <= capAddr;
        togMode <= (capAddr[ADDR_W-1:1] == TOG_ADDR[ADDR_W-1:1]);
      end
      if (ctl.loadStatus) txShift <= statusIn;
      if (ctl.loadByte) begin
        txShift <= byteSel;
        ptr     <= nextPtr;
      end
      if (ctl.shiftOut) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign memAddr    = ptr;
  assign misoOut    = txShift[BYTE_W-1];
  assign toggleMode = togMode;

endmodule

// File: rtl/spi_read_seq.sv
module spi_read_seq
  import spi_rd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] LAST_ADDR = 9'h135,
  parameter logic [ADDR_W-1:0] TOG_ADDR  = 9'h126,
  parameter logic [ADDR_W-1:0] CLK_BASE  = 9'h128,
  parameter int CLK_BYTES = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sckIn,
  input  logic                        csN,
  input  logic                        mosi,
  input  logic [BYTE_W-1:0]           statusIn,
  input  logic [BYTE_W-1:0]           memData,
  input  logic [CLK_BYTES*BYTE_W-1:0] rtcLive,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        misoOut,
  output logic                        misoOe
);

  dpCtrl_t           ctl;
  logic [ADDR_W-1:0] capAddr;
  logic              toggleMode;

  spi_rd_ctrl #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csN(csN), .mosi(mosi),
    .ctl(ctl), .capAddr(capAddr), .misoOe(misoOe)
  );

  spi_rd_dp #(
    .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR),
    .TOG_ADDR(TOG_ADDR), .CLK_BASE(CLK_BASE), .CLK_BYTES(CLK_BYTES)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .capAddr(capAddr),
    .statusIn(statusIn), .memData(memData), .rtcLive(rtcLive),
    .memAddr(memAddr), .misoOut(misoOut), .toggleMode(toggleMode)
  );

endmodule

// File: rtl/spi_read_seq_chk.sv
module spi_read_seq_chk #(
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] LAST_ADDR = 9'h135
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              misoOut,
  input logic              misoOe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              loadByte,
  input logic              txStrobe,
  input logic              toggleMode
);

  logic [2:0] csHist;

  always_ff @(posedge clk) begin
    if (!rstN) csHist <= '0;
    else       csHist <= {csHist[1:0], csN};
  end

  assert_hiz_deselect_R1: assert property (@(posedge clk) disable iff (!rstN)
    (csN && (&csHist)) |-> !misoOe);

  assert_moves_on_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    (misoOe && $past(misoOe) && !$stable(misoOut)) |-> $past(txStrobe));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(loadByte) && !$past(toggleMode)) |->
      (memAddr == (($past(memAddr) == LAST_ADDR) ? '0 : $past(memAddr) + 1'b1)));

  assert_ptr_toggle_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(loadByte) && $past(toggleMode)) |->
      (memAddr == ($past(memAddr) ^ ADDR_W'(1))));

  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(loadByte) && ($past(memAddr) > LAST_ADDR)) |-> !misoOut);

endmodule

bind spi_read_seq spi_read_seq_chk #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .misoOut(misoOut), .misoOe(misoOe),
  .memAddr(memAddr), .loadByte(ctl.loadByte),
  .txStrobe(ctl.loadStatus | ctl.loadByte | ctl.shiftOut),
  .toggleMode(toggleMode)
);

// File: tb/test_spi_read_seq.sv
module test_spi_read_seq;

  localparam int HP = 6;          // SCK half period in system clocks
  localparam int NVEC = 7;
  localparam logic [63:0] LIVE_A = 64'h7776757473727170;

  // {start address, data bytes to read, expected first data byte}
  localparam logic [24:0] VEC [NVEC] = '{
    {9'h005, 8'd4, 8'h14},
    {9'h133, 8'd5, 8'hDD},
    {9'h126, 8'd5, 8'hC8},
    {9'h127, 8'd4, 8'hC9},
    {9'h1FC, 8'd6, 8'h00},
    {9'h12A, 8'd5, 8'h72},
    {9'h0FE, 8'd4, 8'hEF}
  };

  logic        clk = 0;
  logic        rstN = 0;
  logic        sckIn = 1, csN = 1, mosi = 0;
  logic [7:0]  statusIn = 8'h00;
  logic [7:0]  memData;
  logic [63:0] rtcLive = LIVE_A;
  logic [8:0]  memAddr;
  logic        misoOut, misoOe;

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] memModel(logic [8:0] a);
    return a[7:0] ^ (a[8] ? 8'hFF : 8'h00) ^ 8'h11;
  endfunction

  assign memData = memModel(memAddr);

  spi_read_seq i_spi_read_seq (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csN(csN), .mosi(mosi),
    .statusIn(statusIn), .memData(memData), .rtcLive(rtcLive),
    .memAddr(memAddr), .misoOut(misoOut), .misoOe(misoOe)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one SCK period; returns MISO sampled before the rising edge
  task automatic sckBit(input logic b, output logic s, output logic oe,
                        output logic moved);
    @(negedge clk) sckIn = 0; mosi = b;
    repeat (HP) @(negedge clk);
    s = misoOut; oe = misoOe;
    sckIn = 1;
    repeat (HP) @(negedge clk);
    moved = (misoOut !== s);   // no change allowed while SCK high
  endtask

  task automatic sendByte(input logic [7:0] d, output logic anyOe);
    logic s, oe, mv;
    anyOe = 0;
    for (int i = 7; i >= 0; i--) begin
      sckBit(d[i], s, oe, mv);
      anyOe |= oe;
    end
  endtask

  task automatic readByte(output logic [7:0] d, output logic allOe,
                          output logic anyMove);
    logic s, oe, mv;
    allOe = 1; anyMove = 0;
    for (int i = 7; i >= 0; i--) begin
      sckBit(1'b0, s, oe, mv);
      d[i] = s; allOe &= oe; anyMove |= mv;
    end
  endtask

  function automatic logic [7:0] modelByte(logic [8:0] a, logic [63:0] snap);
    if (a > 9'h135) return 8'h00;
    if (a >= 9'h128 && a <= 9'h12F) return snap[(a - 9'h128)*8 +: 8];
    return memModel(a);
  endfunction

  function automatic logic [8:0] modelNext(logic [8:0] a, logic tog);
    if (tog) return a ^ 9'h001;
    if (a == 9'h135) return 9'h000;
    return a + 9'h001;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rx;
    logic        oeAny, oeAll, mv, mvAny, tog;
    logic [8:0]  a;
    logic [63:0] snapExp;

    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);
    check("R1 reset oe", {7'b0, misoOe}, 8'h00);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      a = VEC[v][24:16];
      tog = (a == 9'h126) || (a == 9'h127);
      statusIn = 8'hA0 + 8'(v);
      rtcLive = LIVE_A;
      @(negedge clk) csN = 0;
      repeat (HP) @(negedge clk);
      sendByte({4'b0000, a[8], 3'b011}, oeAny);
      begin
        logic oe2;
        sendByte(a[7:0], oe2);
        oeAny |= oe2;
      end
      check("R1 hi-Z in instruction/address", {7'b0, oeAny}, 8'h00);
      snapExp = LIVE_A;
      rtcLive = ~LIVE_A;           // R8: later change must not be seen
      readByte(rx, oeAll, mvAny);
      check("R3 status first", rx, statusIn);
      check("R1 driven during data", {7'b0, oeAll}, 8'h01);
      for (int k = 0; k < int'(VEC[v][15:8]); k++) begin
        readByte(rx, oeAll, mv);
        mvAny |= mv;
        if (k == 0) check("R5/R6/R7/R8 table first byte", rx, VEC[v][7:0]);
        check("R5 R6 R7 R8 stream byte", rx, modelByte(a, snapExp));
        a = modelNext(a, tog);
      end
      check("R4 MISO steady while SCK high", {7'b0, mvAny}, 8'h00);
      @(negedge clk) csN = 1;
      repeat (2 * HP) @(negedge clk);
      check("R1 hi-Z after deselect", {7'b0, misoOe}, 8'h00);
    end

    // R2: wrong opcode ignored
    @(negedge clk) csN = 0;
    repeat (HP) @(negedge clk);
    sendByte(8'h13, oeAny);
    begin
      logic oe2;
      sendByte(8'h05, oe2); oeAny |= oe2;
      readByte(rx, oeAll, mv); oeAny |= oeAll;
      readByte(rx, oeAll, mv); oeAny |= oeAll;
    end
    check("R2 bad opcode keeps MISO hi-Z", {7'b0, oeAny}, 8'h00);
    @(negedge clk) csN = 1;
    repeat (2 * HP) @(negedge clk);

    // R9: abort in the middle of the address byte, then a clean read
    @(negedge clk) csN = 0;
    repeat (HP) @(negedge clk);
    sendByte(8'h0B, oeAny);
    for (int i = 0; i < 4; i++) begin
      logic s, oe, m2;
      sckBit(1'b1, s, oe, m2);
    end
    @(negedge clk) csN = 1;
    repeat (2 * HP) @(negedge clk);
    statusIn = 8'h5C;
    @(negedge clk) csN = 0;
    repeat (HP) @(negedge clk);
    sendByte(8'h03, oeAny);
    sendByte(8'h10, oeAny);
    readByte(rx, oeAll, mv);
    check("R9 status after abort", rx, 8'h5C);
    readByte(rx, oeAll, mv);
    check("R9 data after abort", rx, memModel(9'h010));
    readByte(rx, oeAll, mv);
    check("R9 R5 next byte after abort", rx, memModel(9'h011));
    @(negedge clk) csN = 1;
    repeat (2 * HP) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule